// File: doc/BRIEF.md
# Fractional-N Tuning Sequencer

This block takes a receive frequency in kHz and programs a fractional-N synthesizer through a register-write port. On a start pulse it latches the frequency and runs a bit-serial restoring division. The division gives a 16.16 fixed-point divider relative to a 12.8 MHz reference halved: the value is floor(f_khz × 131072 / 12800). The integer part is N, which must fit in 11 bits, and the fraction is K.

The band code comes from two frequency thresholds. The block then writes three registers one at a time: the integer word first, then the fractional word, then the control word that carries the band. After that it waits a fixed number of clock cycles for the synthesizer to lock, and then pulses `done`.

If N does not fit, the block issues no writes and reports the overflow. If the write port rejects a transfer, the sequence stops at once and reports the error. Before the 5 ms settling time can be met, `LOCK_CYCLES` must be set for the system clock rate.

The states are:
- IDLE: waits for a start pulse.
- DIVIDE: runs the serial division.
- RANGE_CHECK: tests the width of N.
- WR_N, WR_K and WR_CTRL: perform the three writes.
- LOCK_WAIT: runs the settling timer.
- FINISH: holds the one-cycle completion pulse.

The transitions are:
- IDLE→DIVIDE on start.
- DIVIDE→RANGE_CHECK when the quotient is ready.
- RANGE_CHECK→FINISH on overflow, and RANGE_CHECK→WR_N otherwise.
- From each WR_* state on an acknowledge: to the next write state, or from WR_CTRL to LOCK_WAIT. An acknowledge with error goes to FINISH instead.
- LOCK_WAIT→FINISH when the timer expires.
- FINISH→IDLE.

Top module: `tune_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wr_valid`, `error` and `range_err` are all 0.
- R2: With q = floor(freq × 131072 / 12800), the data written to address 0x29 is q[26:16] zero-extended to 16 bits. The data written to address 0x2A is q[15:0].
- R3: A full sequence writes exactly three times, in the order 0x29, 0x2A, 0x30. Each request holds `wr_valid`, `wr_addr` and `wr_data` steady until the cycle in which `wr_ack` is high.
- R4: The data written to 0x30 carries the band in bits [15:8] and the parameter `CTRL_LOW` (default 0x00) in bits [7:0]. The band is 0x00 below 200000 kHz, 0x01 from 200000 to 299999 kHz, and 0x02 from 300000 kHz up.
- R5: When q ≥ 2^27, no write is issued. `done` then pulses with `range_err`=1 and `error`=0.
- R6: `done` rises in the cycle that follows exactly `LOCK_CYCLES` clock edges after the edge that accepts the acknowledge of the 0x30 write.
- R7: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` lasts one cycle, and `busy` is low after it.
- R8: An acknowledge with `wr_err`=1 ends the sequence. No further write follows, there is no lock wait, and `done` pulses in the next cycle with `error`=1.
- R9: A start pulse while `busy` is high has no effect on the writes or their data.
- R10: `error` and `range_err` keep their values after `done` until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning sequence (accepted when idle) |
| freq_khz | input | FREQ_W | Target receive frequency in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | A register write was rejected |
| range_err | output | 1 | Integer divider exceeded 11 bits |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 8 | Register address of the request |
| wr_data | output | 16 | Register data of the request |
| wr_ack | input | 1 | Write port completed the request |
| wr_err | input | 1 | Write failed, valid with wr_ack |

## Verification
The assertions assume that `wr_ack` comes only while `wr_valid` is high, lasts a single cycle, and is followed by a low cycle before the next acknowledge. They also assume that `wr_err` has meaning only alongside `wr_ack`. The bench write responder works in exactly this way: it acknowledges after a random delay of zero to two cycles and always drops `wr_ack` for a cycle afterwards. Random frequencies are kept below 13107200 kHz, so any overflow comes only from the directed boundary values.

// File: rtl/tune_seq_pkg.sv
package tune_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIVIDE,
        S_RANGE_CHECK,
        S_WR_N,
        S_WR_K,
        S_WR_CTRL,
        S_LOCK_WAIT,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        BAND_VLO = 2'd0,
        BAND_VHI = 2'd1,
        BAND_UHF = 2'd2
    } band_t;

    localparam logic [7:0] ADDR_INT  = 8'h29;
    localparam logic [7:0] ADDR_FRAC = 8'h2A;
    localparam logic [7:0] ADDR_CTRL = 8'h30;

endpackage

// File: rtl/tune_divider.sv
module tune_divider #(
    parameter int NUM_W = 41,
    parameter int DEN_W = 14,
    parameter int DENOM = 12800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    output logic             ready,
    output logic [NUM_W-1:0] quotient
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [DEN_W:0] DEN_V = (DEN_W + 1)'(DENOM);

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] acc;
    logic [CNT_W-1:0] steps;
    logic [DEN_W:0]   trial;

    always_comb trial = {rem, acc[NUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            acc   <= '0;
            steps <= '0;
            ready <= 1'b0;
        end else begin
            ready <= (steps == CNT_W'(1)) && !go;
            if (go) begin
                rem   <= '0;
                acc   <= dividend;
                steps <= CNT_W'(NUM_W);
            end else if (steps != '0) begin
                if (trial >= DEN_V) begin
                    rem <= DEN_W'(trial - DEN_V);
                    acc <= {acc[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DEN_W-1:0];
                    acc <= {acc[NUM_W-2:0], 1'b0};
                end
                steps <= steps - CNT_W'(1);
            end
        end
    end

    assign quotient = acc;
endmodule

// File: rtl/tune_band_decode.sv
module tune_band_decode
    import tune_seq_pkg::*;
#(
    parameter int FREQ_W     = 24,
    parameter int VHI_KHZ    = 200000,
    parameter int UHF_KHZ    = 300000
) (
    input  logic [FREQ_W-1:0] freq,
    output band_t             band
);
    always_comb begin
        if (freq < FREQ_W'(VHI_KHZ))      band = BAND_VLO;
        else if (freq < FREQ_W'(UHF_KHZ)) band = BAND_VHI;
        else                              band = BAND_UHF;
    end
endmodule

// File: rtl/tune_lock_timer.sv
module tune_lock_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                remaining <= '0;
        else if (load)             remaining <= CNT_W'(CYCLES);
        else if (remaining != '0)  remaining <= remaining - CNT_W'(1);
    end

    assign expired = (remaining == CNT_W'(1));
endmodule

// File: rtl/tune_seq.sv
module tune_seq
    import tune_seq_pkg::*;
#(
    parameter int         FREQ_W      = 24,
    parameter int         REF_KHZ     = 12800,
    parameter int         N_W         = 11,
    parameter int         FRAC_W      = 16,
    parameter int         LOCK_CYCLES = 1000000,
    parameter logic [7:0] CTRL_LOW    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              range_err,
    output logic              wr_valid,
    output logic [7:0]        wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_ack,
    input  logic              wr_err
);
    localparam int SHIFT = FRAC_W + 1;
    localparam int NUM_W = FREQ_W + SHIFT;
    localparam int DEN_W = $clog2(REF_KHZ + 1);
    localparam int TOP_B = FRAC_W + N_W;

    seq_state_t state, next_state;

    logic [FREQ_W-1:0] freq_q;
    logic [NUM_W-1:0]  quo;
    logic              div_ready;
    logic              accept;
    logic              overflow;
    logic              timer_load;
    logic              lock_done;
    logic              ack_ok;
    logic              ack_bad;
    band_t             band;
    logic [N_W-1:0]    n_word;
    logic [FRAC_W-1:0] k_word;

    assign accept   = (state == S_IDLE) && start;
    assign overflow = |quo[NUM_W-1:TOP_B];
    assign n_word   = quo[FRAC_W +: N_W];
    assign k_word   = quo[FRAC_W-1:0];
    assign ack_ok   = wr_valid && wr_ack && !wr_err;
    assign ack_bad  = wr_valid && wr_ack && wr_err;
    assign timer_load = (state == S_WR_CTRL) && ack_ok;

    tune_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .DENOM(REF_KHZ)) u_div (
        .clk(clk), .rst_n(rst_n), .go(accept),
        .dividend({freq_khz, SHIFT'(0)}),
        .ready(div_ready), .quotient(quo)
    );

    tune_band_decode #(.FREQ_W(FREQ_W)) u_band (
        .freq(freq_q), .band(band)
    );

    tune_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(lock_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:        if (start) next_state = S_DIVIDE;
            S_DIVIDE:      if (div_ready) next_state = S_RANGE_CHECK;
            S_RANGE_CHECK: next_state = overflow ? S_FINISH : S_WR_N;
            S_WR_N:        if (wr_ack) next_state = wr_err ? S_FINISH : S_WR_K;
            S_WR_K:        if (wr_ack) next_state = wr_err ? S_FINISH : S_WR_CTRL;
            S_WR_CTRL:     if (wr_ack) next_state = wr_err ? S_FINISH : S_LOCK_WAIT;
            S_LOCK_WAIT:   if (lock_done) next_state = S_FINISH;
            S_FINISH:      next_state = S_IDLE;
            default:       next_state = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
        wr_valid = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        unique case (state)
            S_WR_N: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_INT;
                wr_data  = 16'(n_word);
            end
            S_WR_K: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_FRAC;
                wr_data  = 16'(k_word);
            end
            S_WR_CTRL: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_CTRL;
                wr_data  = {6'd0, band, CTRL_LOW};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q    <= '0;
            error     <= 1'b0;
            range_err <= 1'b0;
        end else begin
            if (accept) begin
                freq_q    <= freq_khz;
                error     <= 1'b0;
                range_err <= 1'b0;
            end
            if ((state == S_RANGE_CHECK) && overflow) range_err <= 1'b1;
            if (ack_bad) error <= 1'b1;
        end
    end
endmodule

// File: rtl/tune_seq_checker.sv
module tune_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        range_err,
    input logic        wr_valid,
    input logic [7:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        wr_ack,
    input logic        wr_err
);
    assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_addr_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr == 8'h29 || wr_addr == 8'h2A || wr_addr == 8'h30));

    assert_band_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr == 8'h30 |-> wr_data[15:10] == 6'd0 && wr_data[9:8] != 2'b11);

    assert_no_write_on_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !range_err);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_abort_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ack && wr_err |=> done && error && !wr_valid);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);
endmodule

bind tune_seq tune_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .range_err(range_err), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err)
);

// File: tb/tune_seq_test.sv
`timescale 1ns/1ps
module tune_seq_test;
    localparam int LOCK = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] freq_khz = '0;
    logic        busy, done, error, range_err, wr_valid;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        wr_err = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_count = 0;
    int err_at = -1;
    int delay_left = 0;
    int ack_cyc = 0;
    logic [7:0]  log_addr [0:7];
    logic [15:0] log_data [0:7];

    tune_seq #(.LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
        .busy(busy), .done(done), .error(error), .range_err(range_err),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (wr_ack) begin
            wr_ack = 1'b0;
            wr_err = 1'b0;
        end else if (wr_valid) begin
            if (delay_left > 0) delay_left--;
            else begin
                if (wr_count < 8) begin
                    log_addr[wr_count] = wr_addr;
                    log_data[wr_count] = wr_data;
                end
                wr_err = (wr_count == err_at);
                wr_ack = 1'b1;
                ack_cyc = cyc;
                wr_count++;
                delay_left = int'($urandom % 3);
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint ref_q(input longint f);
        return (f << 17) / 12800;
    endfunction

    function automatic int ref_band(input longint f);
        if (f < 200000) return 0;
        if (f < 300000) return 1;
        return 2;
    endfunction

    task automatic run_case(input longint f, input int inject, input bit poke);
        longint q;
        int done_cyc;
        int waited;
        bit got;
        int band;
        logic err_s, rng_s;
        q = ref_q(f);
        band = ref_band(f);
        err_at = inject;
        wr_count = 0;
        @(negedge clk);
        start = 1'b1;
        freq_khz = 24'(f);
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", busy, 1);
        got = 0;
        done_cyc = 0;
        for (waited = 0; waited < 5000 && !got; waited++) begin
            @(negedge clk);
            if (poke && waited == 10) begin
                start = 1'b1;
                freq_khz = 24'(f + 123457);
            end else start = 1'b0;
            if (done) begin
                got = 1;
                done_cyc = cyc;
            end
        end
        start = 1'b0;
        check("R7 done seen", got, 1);
        if (q >= (64'd1 << 27)) begin
            check("R5 no writes", wr_count, 0);
            check("R5 range flag", range_err, 1);
            check("R5 error flag", error, 0);
        end else if (inject >= 0) begin
            check("R8 write count", wr_count, inject + 1);
            check("R8 error flag", error, 1);
            check("R8 no lock wait", done_cyc - ack_cyc, 1);
        end else begin
            check("R3 write count", wr_count, 3);
            check("R3 addr0", log_addr[0], 8'h29);
            check("R3 addr1", log_addr[1], 8'h2A);
            check("R3 addr2", log_addr[2], 8'h30);
            check("R2 int word", log_data[0], (q >> 16) & 16'h07FF);
            check("R2 frac word", log_data[1], q & 16'hFFFF);
            check("R4 ctrl word", log_data[2], band << 8);
            check("R6 lock wait", done_cyc - ack_cyc, LOCK + 1);
            check("R8 no error", error, 0);
            check("R5 range clear", range_err, 0);
            if (poke) check("R9 start ignored", wr_count, 3);
        end
        err_s = error;
        rng_s = range_err;
        @(negedge clk);
        check("R7 done one cycle", done, 0);
        check("R7 busy low", busy, 0);
        repeat (4) @(negedge clk);
        check("R10 error held", error, err_s);
        check("R10 range held", rng_s, range_err);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 error", error, 0);
        check("R1 range", range_err, 0);
        rst_n = 1'b1;
        run_case(146520, -1, 0);
        run_case(199999, -1, 0);
        run_case(200000, -1, 0);
        run_case(299999, -1, 0);
        run_case(300000, -1, 0);
        run_case(13107199, -1, 0);
        run_case(13107200, -1, 0);
        run_case(446000, -1, 0);
        run_case(16777215, -1, 0);
        run_case(222220, 0, 0);
        run_case(433500, 1, 0);
        run_case(150000, 2, 0);
        run_case(145000, -1, 1);
        for (int i = 0; i < 24; i++) begin
            longint f;
            if (i % 2 == 0) f = 130000 + longint'($urandom % 400000);
            else            f = 100000 + longint'($urandom % 13007100);
            run_case(f, (i % 5 == 4) ? int'($urandom % 3) : -1, (i % 7 == 3));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule